// File: doc/BRIEF.md
# SDRAM Bank Precharge and Burst Controller

This block is the command-side control logic of a four-bank synchronous DRAM. On every rising clock edge it decodes the active-low row strobe, column strobe and write-enable pins, together with the two bank-select bits and address bit 10. It keeps an open or closed flag for each bank and runs a single data burst engine shared by all banks. The engine raises a data-out valid strobe for reads and a data-in accept strobe for writes.

Precharge can be explicit, for one bank or for all banks. It can also be automatic: a read or write issued with address bit 10 set closes its bank at a fixed point near the end of its burst. A running burst can be cut short by a new read or write, by a precharge that covers its bank, or by a burst-stop command. Burst stop leaves the bank open. The CAS latency arrives as a static input (2, 3 or 4). The burst length and the write recovery time are parameters.

Top module: `sdram_bank_ctl`

## Requirements
- R1: Command pins are decoded as {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no operation. After reset all banks are closed and every output is low. An activate opens bank {ba}, and bank_open[ba] is high from the next cycle.
- R2: A precharge with a10 low drives pre_start[ba] high in the command cycle, and bank_open[ba] is low from the next cycle.
- R3: A precharge with a10 high drives pre_start to 4'b1111 whatever ba is, and all four banks are closed from the next cycle.
- R4: A read issued on edge T to an open bank holds dout_valid high in the cycles sampled by edges T+CL through T+CL+BL-1, where CL is cas_lat clamped to the range 2..4.
- R5: A write issued to an open bank holds din_accept high in the command cycle and in the BL-1 cycles that follow it.
- R6: A read issued with a10 high pulses pre_start for its bank in the cycle sampled by edge T+BL, which is CL-1 edges before the last data-out beat. The burst still completes, and the bank reads closed afterwards.
- R7: A write issued with a10 high pulses pre_start for its bank in the cycle sampled by edge T+BL-1+TWR, which is TWR edges after the last data-in beat.
- R8: A new read or write cuts off a running burst: a cut read shows dout_valid low from the next cycle, and a cut write shows din_accept low from the next cycle.
- R9: A precharge that covers the bank of a running burst ends that burst from the next cycle and closes the bank.
- R10: Burst stop drops din_accept in its own cycle and dout_valid from the next cycle, and it leaves every bank's open state unchanged.
- R11: A read or write to a closed bank raises access_err in the command cycle and starts no burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge on read/write, all-banks on precharge |
| cas_lat | input | 3 | CAS latency, 2 to 4 |
| bank_open | output | 4 | Per-bank open flag |
| dout_valid | output | 1 | Read data beat on the bus |
| din_accept | output | 1 | Write data beat is taken |
| pre_start | output | 4 | Precharge begins in this cycle, per bank |
| access_err | output | 1 | Column access to a closed bank |

## Verification
The assertions check, on every cycle, the rules that need no knowledge of latency:
- a bank opens only after an activate;
- any precharge-start event leaves its bank closed on the next cycle;
- an all-bank precharge raises all four precharge strobes;
- an accepted write beat is either the command itself or continues an unbroken run;
- burst stop silences both data strobes.

The placement of the data windows against CAS latency and burst length can only be shown by the bench's scenarios. So can the exact cycle of each automatic precharge, the three ways of cutting a burst short, and the rejection of accesses to closed banks. The bench checks these against windows it computes itself.

// File: rtl/sdram_bank_ctl.sv
module sdram_bank_ctl #(
  parameter int BL  = 4,
  parameter int TWR = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       a10,
  input  logic [2:0] cas_lat,
  output logic [3:0] bank_open,
  output logic       dout_valid,
  output logic       din_accept,
  output logic [3:0] pre_start,
  output logic       access_err
);
  localparam int RW  = $clog2(BL + 1);
  localparam int APW = $clog2(BL + TWR + 1);

  logic [2:0]     rd_wait;
  logic [RW-1:0]  rd_left, wr_left;
  logic [APW-1:0] ap_cnt;
  logic [1:0]     ap_bank, bur_bank;
  logic [2:0]     cl_eff;
  logic [3:0]     sel, pre_mask;

  wire cmd_act = !ras_n &&  cas_n &&  we_n;
  wire cmd_rd  =  ras_n && !cas_n &&  we_n;
  wire cmd_wr  =  ras_n && !cas_n && !we_n;
  wire cmd_pre = !ras_n &&  cas_n && !we_n;
  wire cmd_bst =  ras_n &&  cas_n && !we_n;

  assign sel      = 4'b0001 << ba;
  wire   hit      = |(bank_open & sel);
  wire   go_rd    = cmd_rd && hit;
  wire   go_wr    = cmd_wr && hit;
  assign pre_mask = cmd_pre ? (a10 ? 4'b1111 : sel) : 4'b0000;
  wire   ap_fire  = (ap_cnt == APW'(1));
  wire   bur_cut  = cmd_bst || pre_mask[bur_bank];

  assign access_err = (cmd_rd || cmd_wr) && !hit;
  assign pre_start  = pre_mask | (ap_fire ? (4'b0001 << ap_bank) : 4'b0000);
  assign dout_valid = (rd_wait == 3'd0) && (rd_left != '0);
  assign din_accept = go_wr || ((wr_left != '0) && !bur_cut && !go_rd);

  always_comb begin
    if (cas_lat < 3'd2)      cl_eff = 3'd2;
    else if (cas_lat > 3'd4) cl_eff = 3'd4;
    else                     cl_eff = cas_lat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= '0;
      rd_wait   <= '0;
      rd_left   <= '0;
      wr_left   <= '0;
      ap_cnt    <= '0;
      ap_bank   <= '0;
      bur_bank  <= '0;
    end else begin
      bank_open <= (bank_open & ~pre_start) | (cmd_act ? (sel & ~pre_start) : 4'b0000);

      if (go_rd) begin
        rd_wait  <= cl_eff - 3'd1;
        rd_left  <= RW'(BL);
        wr_left  <= '0;
        bur_bank <= ba;
      end else if (go_wr) begin
        wr_left  <= RW'(BL - 1);
        rd_left  <= '0;
        rd_wait  <= '0;
        bur_bank <= ba;
      end else if (bur_cut) begin
        rd_left <= '0;
        wr_left <= '0;
        rd_wait <= '0;
      end else begin
        if (rd_wait != 3'd0)     rd_wait <= rd_wait - 3'd1;
        else if (rd_left != '0)  rd_left <= rd_left - RW'(1);
        if (wr_left != '0)       wr_left <= wr_left - RW'(1);
      end

      if ((go_rd || go_wr) && a10) begin
        ap_cnt  <= go_rd ? APW'(BL) : APW'(BL - 1 + TWR);
        ap_bank <= ba;
      end else if (pre_mask[ap_bank]) begin
        ap_cnt <= '0;
      end else if (ap_cnt != '0) begin
        ap_cnt <= ap_cnt - APW'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_bank_ctl_chk.sv
module sdram_bank_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       a10,
  input logic [3:0] bank_open,
  input logic       dout_valid,
  input logic       din_accept,
  input logic [3:0] pre_start
);
  // R1
  open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_open & ~$past(bank_open)) != 4'b0000) |-> $past(!ras_n && cas_n && we_n));

  // R2
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_start != 4'b0000) |=> ((bank_open & $past(pre_start)) == 4'b0000));

  // R3
  all_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n && !we_n && a10) |-> (pre_start == 4'b1111));

  // R5
  wr_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_accept |-> ((ras_n && !cas_n && !we_n) || $past(din_accept)));

  // R10
  bst_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n && !we_n) |-> !din_accept);

  // R10
  bst_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n && !we_n) |=> !dout_valid);
endmodule

bind sdram_bank_ctl sdram_bank_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
  .bank_open(bank_open), .dout_valid(dout_valid), .din_accept(din_accept),
  .pre_start(pre_start)
);

// File: tb/test_sdram_bank_ctl.sv
module test_sdram_bank_ctl;
  localparam int BL  = 4;
  localparam int TWR = 2;
  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, BST = 3'b110, NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [2:0] cas_lat = 3'd2;
  logic [3:0] bank_open, pre_start;
  logic dout_valid, din_accept, access_err;
  logic [3:0] c_pre;
  logic c_acc, c_err;
  int checks = 0, fails = 0;

  sdram_bank_ctl #(.BL(BL), .TWR(TWR)) i_sdram_bank_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .cas_lat(cas_lat), .bank_open(bank_open),
    .dout_valid(dout_valid), .din_accept(din_accept), .pre_start(pre_start),
    .access_err(access_err)
  );

  always #5 clk = ~clk;

  function automatic bit exp_rd(int j, int cl);
    return (j >= cl - 1) && (j <= cl + BL - 2);
  endfunction

  function automatic logic [3:0] exp_mask(logic all, logic [1:0] b);
    return all ? 4'b1111 : (4'b0001 << b);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic [1:0] b, logic a);
    {ras_n, cas_n, we_n} = c; ba = b; a10 = a;
    #1;
    c_pre = pre_start; c_acc = din_accept; c_err = access_err;
    @(negedge clk);
    {ras_n, cas_n, we_n} = NOP; a10 = 1'b0;
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset bank_open", bank_open, 0);
    check("R1 reset dout_valid", dout_valid, 0);
    check("R1 reset pre_start", pre_start, 0);
    rst_n = 1'b1;
    idle(1);

    for (int b = 0; b < 4; b++) issue(ACT, 2'(b), 1'b0);
    check("R1 activate all", bank_open, 15);

    for (int cl = 2; cl <= 4; cl++) begin
      cas_lat = 3'(cl);
      issue(RD, 2'd1, 1'b0);
      for (int j = 0; j <= cl + BL + 1; j++) begin
        check("R4 read window", dout_valid, exp_rd(j, cl));
        idle(1);
      end
    end

    issue(WR, 2'd2, 1'b0);
    check("R5 write first beat", c_acc, 1);
    for (int j = 0; j <= BL; j++) begin
      check("R5 write beats", din_accept, (j <= BL - 2));
      idle(1);
    end

    cas_lat = 3'd3;
    issue(RD, 2'd0, 1'b0);
    idle(2);
    check("R10 read running before stop", dout_valid, 1);
    issue(BST, 2'd0, 1'b0);
    for (int j = 0; j < 3; j++) begin
      check("R10 read stopped", dout_valid, 0);
      idle(1);
    end
    check("R10 bank kept open", bank_open, 15);

    issue(WR, 2'd3, 1'b0);
    check("R10 write beat before stop", din_accept, 1);
    issue(BST, 2'd3, 1'b0);
    check("R10 stop cycle ignores data", c_acc, 0);
    check("R10 write stopped", din_accept, 0);
    check("R10 bank kept open after write stop", bank_open, 15);
    idle(BL);

    cas_lat = 3'd2;
    issue(RD, 2'd1, 1'b0);
    issue(WR, 2'd2, 1'b0);
    check("R8 write cuts read accept", c_acc, 1);
    check("R8 read cut", dout_valid, 0);
    issue(RD, 2'd1, 1'b0);
    check("R8 write cut by read", din_accept, 0);
    idle(BL + 3);

    issue(RD, 2'd1, 1'b0);
    issue(PRE, 2'd1, 1'b0);
    check("R2 single precharge strobe", c_pre, 2);
    check("R9 burst ended by precharge", dout_valid, 0);
    check("R2 bank closed", bank_open, 13);
    idle(3);

    issue(RD, 2'd1, 1'b0);
    check("R11 read closed error", c_err, 1);
    for (int j = 0; j <= 2 + BL; j++) begin
      check("R11 no read burst", dout_valid, 0);
      idle(1);
    end
    issue(WR, 2'd1, 1'b0);
    check("R11 write closed error", c_err, 1);
    check("R11 write not accepted", c_acc, 0);
    check("R11 no write burst", din_accept, 0);

    issue(ACT, 2'd1, 1'b0);
    cas_lat = 3'd3;
    issue(RD, 2'd1, 1'b1);
    for (int j = 0; j <= 3 + BL; j++) begin
      check("R6 auto precharge timing", pre_start, (j == BL - 1) ? 2 : 0);
      check("R6 burst completes", dout_valid, exp_rd(j, 3));
      if (j >= BL) check("R6 bank closed", bank_open[1], 0);
      idle(1);
    end

    issue(WR, 2'd2, 1'b1);
    for (int j = 0; j <= BL + TWR; j++) begin
      check("R7 write auto precharge timing", pre_start, (j == BL + TWR - 2) ? 4 : 0);
      idle(1);
    end
    check("R7 bank closed", bank_open[2], 0);

    for (int b = 0; b < 4; b++) issue(ACT, 2'(b), 1'b0);
    issue(PRE, 2'd1, 1'b1);
    check("R3 all precharge strobe", c_pre, 15);
    check("R3 all closed", bank_open, 0);

    void'($urandom(32'd4242));
    for (int k = 0; k < 12; k++) begin
      logic [1:0] rb;
      logic ra;
      int rcl;
      rb  = 2'($urandom_range(0, 3));
      rcl = int'($urandom_range(2, 4));
      ra  = 1'($urandom_range(0, 1));
      cas_lat = 3'(rcl);
      issue(ACT, rb, 1'b0);
      issue(RD, rb, 1'b0);
      for (int j = 0; j <= rcl + BL + 1; j++) begin
        check("R4 random read window", dout_valid, exp_rd(j, rcl));
        idle(1);
      end
      issue(PRE, rb, ra);
      check("R2 random precharge mask", c_pre, exp_mask(ra, rb));
      check("R2 random bank closed", bank_open & exp_mask(ra, rb), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule